// File: doc/BRIEF.md
# DRAM Strobe Cycle-Type Decoder

This block is the control logic of an asynchronous-strobe DRAM device, with the strobe pins sampled by a fast internal clock. It watches the active-low row strobe, four active-low column strobes (one per data lane), the active-low write line and the active-low output enable. From the order in which these lines change, it decides what kind of cycle is running. It also keeps the internal refresh row counter and drives the enable of the tri-state data outputs.

When the row strobe falls, the block sorts the cycle into one of these kinds: a row-addressed cycle, a counter-driven refresh with the column strobe already low, a hidden refresh, or test-mode entry. When the first column strobe falls inside a row-addressed cycle, it refines the cycle into a read, an early write or, if the write line falls later, a read-modify-write. The row and column addresses are latched on the correct edges. A write produces a one-cycle strobe that carries a lane mask.

Top module: `dram_strobe_decoder`

## Requirements
- R1: After reset, cycle_type_o is 0 (idle), test_mode_o, dq_oe_o and wr_stb_o are 0, and ref_row_o is 0.
- R2: When the row strobe falls while any column strobe is low and the write line is high, cycle_type_o becomes 2 (counter refresh), and row_o takes the refresh counter value.
- R3: When the row strobe falls while any column strobe is low and the write line is low, cycle_type_o becomes 4 (test entry), and test_mode_o becomes 1.
- R4: When the row strobe falls while all column strobes are high, cycle_type_o becomes 1, and row_o latches addr_i. If no column strobe falls, the type stays 1 until the row strobe rises, which is a row-only refresh.
- R5: Suppose a column strobe stays low from a read or write through a rise and fall of the row strobe. That new row cycle is type 3 (hidden refresh), and it uses the refresh counter for row_o.
- R6: If the write line is low when the first column strobe falls in a type-1 cycle, the type becomes 6 (early write). wr_stb_o then pulses for one cycle, with wr_lane_o bit i set for each low column strobe i, and dq_oe_o stays 0.
- R7: If the write line is high when the first column strobe falls in a type-1 cycle, the type becomes 5 (read), and col_o latches addr_i. From then on, dq_oe_o follows the inverse of oe_n_i.
- R8: If the write line falls during a read while a column strobe is low, the type becomes 7 (read-modify-write). wr_stb_o pulses for one cycle, and the outputs stay enabled.
- R9: The data outputs turn off only once the row strobe and all column strobes are high, that is, when the later of the two rises.
- R10: The refresh counter advances by one when the row strobe rises at the end of a type-2 or type-3 cycle, and it wraps from 4095 to 0.
- R11: Test mode is left at the fall of a counter or hidden refresh, or at the end of a row-only refresh. Read and write cycles leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 4 | Per-lane column strobes, active low |
| we_n_i | input | 1 | Write line, active low |
| oe_n_i | input | 1 | Output enable, active low |
| addr_i | input | 12 | Multiplexed address |
| cycle_type_o | output | 3 | Decoded cycle type (codes in R1 to R8) |
| test_mode_o | output | 1 | Test mode flag |
| row_o | output | 12 | Row used by the current cycle |
| col_o | output | 12 | Latched column |
| ref_row_o | output | 12 | Refresh row counter |
| wr_stb_o | output | 1 | One-cycle array write strobe |
| wr_lane_o | output | 4 | Lanes written by the strobe |
| dq_oe_o | output | 1 | Data output driver enable |

## Verification
Hidden refresh is the case where two functions share one cycle. Read data must stay on the pins while a refresh row is issued and the counter advances at the end of that refresh. The bench provokes this by holding a column strobe low through a full row-strobe rise and fall after a read. It then judges the cycle type, row_o against the counter, dq_oe_o and the counter step at the same sample points. The same cycles also show which strobe's rise turns the outputs off.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE   = 3'd0,
    CYC_ROWSEL = 3'd1,
    CYC_CBR    = 3'd2,
    CYC_HIDDEN = 3'd3,
    CYC_TEST   = 3'd4,
    CYC_READ   = 3'd5,
    CYC_EWRITE = 3'd6,
    CYC_RMW    = 3'd7
  } cyc_e;
endpackage

// File: rtl/strobe_sampler.sv
module strobe_sampler #(
  parameter int LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_n_i,
  input  logic [LANES-1:0] cas_n_i,
  input  logic             we_n_i,
  output logic             ras_fall_o,
  output logic             ras_rise_o,
  output logic             cas_low_o,
  output logic             cas_fall_o,
  output logic             we_fall_o
);
  logic ras_q, cas_low_q, we_q;

  assign cas_low_o  = ~&cas_n_i;
  assign ras_fall_o = ras_q & ~ras_n_i;
  assign ras_rise_o = ~ras_q & ras_n_i;
  assign cas_fall_o = cas_low_o & ~cas_low_q;
  assign we_fall_o  = we_q & ~we_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q     <= 1'b1;
      cas_low_q <= 1'b0;
      we_q      <= 1'b1;
    end else begin
      ras_q     <= ras_n_i;
      cas_low_q <= cas_low_o;
      we_q      <= we_n_i;
    end
  end
endmodule

// File: rtl/refresh_counter.sv
module refresh_counter #(
  parameter int ROW_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [ROW_W-1:0] row_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_o <= '0;
    else if (inc_i) row_o <= row_o + 1'b1;  // natural wrap at 2**ROW_W
  end
endmodule

// File: rtl/cycle_classifier.sv
module cycle_classifier
  import dram_dec_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_n_i,
  input  logic [LANES-1:0]  cas_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ras_fall_i,
  input  logic              ras_rise_i,
  input  logic              cas_low_i,
  input  logic              cas_fall_i,
  input  logic              we_fall_i,
  input  logic [ADDR_W-1:0] ref_row_i,
  output cyc_e              cycle_type_o,
  output logic              test_mode_o,
  output logic [ADDR_W-1:0] row_o,
  output logic [ADDR_W-1:0] col_o,
  output logic              wr_stb_o,
  output logic [LANES-1:0]  wr_lane_o,
  output logic              rd_start_o,
  output logic              ref_inc_o
);
  logic cas_held_q;
  logic first_cas, ewr_start, rmw_start;

  assign first_cas  = cas_fall_i & ~ras_n_i & (cycle_type_o == CYC_ROWSEL);
  assign rd_start_o = first_cas & we_n_i;
  assign ewr_start  = first_cas & ~we_n_i;
  assign rmw_start  = we_fall_i & cas_low_i & (cycle_type_o == CYC_READ);
  assign ref_inc_o  = ras_rise_i &
                      ((cycle_type_o == CYC_CBR) || (cycle_type_o == CYC_HIDDEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cycle_type_o <= CYC_IDLE;
      test_mode_o  <= 1'b0;
      row_o        <= '0;
      col_o        <= '0;
      cas_held_q   <= 1'b0;
      wr_stb_o     <= 1'b0;
      wr_lane_o    <= '0;
    end else begin
      wr_stb_o <= ewr_start | rmw_start;
      if (ewr_start | rmw_start) wr_lane_o <= ~cas_n_i;
      // held-low flag survives a row strobe rise; drops with all column strobes
      if (!cas_low_i)     cas_held_q <= 1'b0;
      else if (first_cas) cas_held_q <= 1'b1;

      if (ras_fall_i) begin
        if (cas_low_i && !we_n_i) begin
          cycle_type_o <= CYC_TEST;
          test_mode_o  <= 1'b1;
        end else if (cas_low_i) begin
          cycle_type_o <= cas_held_q ? CYC_HIDDEN : CYC_CBR;
          test_mode_o  <= 1'b0;
          row_o        <= ref_row_i;
        end else begin
          cycle_type_o <= CYC_ROWSEL;
          row_o        <= addr_i;
        end
      end else if (ras_rise_i) begin
        if (cycle_type_o == CYC_ROWSEL) test_mode_o <= 1'b0;
        cycle_type_o <= CYC_IDLE;
      end else if (first_cas) begin
        col_o        <= addr_i;
        cycle_type_o <= we_n_i ? CYC_READ : CYC_EWRITE;
      end else if (rmw_start) begin
        cycle_type_o <= CYC_RMW;
      end
    end
  end
endmodule

// File: rtl/dq_enable.sv
module dq_enable #(
  parameter int LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_n_i,
  input  logic [LANES-1:0] cas_n_i,
  input  logic             oe_n_i,
  input  logic             rd_start_i,
  output logic             dq_oe_o
);
  logic data_on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       data_on_q <= 1'b0;
    else if (ras_n_i && (&cas_n_i))    data_on_q <= 1'b0;
    else if (rd_start_i)               data_on_q <= 1'b1;
  end

  assign dq_oe_o = data_on_q & ~oe_n_i;
endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
  import dram_dec_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_n_i,
  input  logic [LANES-1:0]  cas_n_i,
  input  logic              we_n_i,
  input  logic              oe_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [2:0]        cycle_type_o,
  output logic              test_mode_o,
  output logic [ADDR_W-1:0] row_o,
  output logic [ADDR_W-1:0] col_o,
  output logic [ADDR_W-1:0] ref_row_o,
  output logic              wr_stb_o,
  output logic [LANES-1:0]  wr_lane_o,
  output logic              dq_oe_o
);
  logic ras_fall, ras_rise, cas_low, cas_fall, we_fall;
  logic rd_start, ref_inc;
  cyc_e cyc;

  strobe_sampler #(.LANES(LANES)) u_smp (
    .clk_i, .rst_ni, .ras_n_i, .cas_n_i, .we_n_i,
    .ras_fall_o(ras_fall), .ras_rise_o(ras_rise), .cas_low_o(cas_low),
    .cas_fall_o(cas_fall), .we_fall_o(we_fall)
  );

  refresh_counter #(.ROW_W(ADDR_W)) u_ref (
    .clk_i, .rst_ni, .inc_i(ref_inc), .row_o(ref_row_o)
  );

  cycle_classifier #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cls (
    .clk_i, .rst_ni, .ras_n_i, .cas_n_i, .we_n_i, .addr_i,
    .ras_fall_i(ras_fall), .ras_rise_i(ras_rise), .cas_low_i(cas_low),
    .cas_fall_i(cas_fall), .we_fall_i(we_fall), .ref_row_i(ref_row_o),
    .cycle_type_o(cyc), .test_mode_o, .row_o, .col_o,
    .wr_stb_o, .wr_lane_o, .rd_start_o(rd_start), .ref_inc_o(ref_inc)
  );

  dq_enable #(.LANES(LANES)) u_dq (
    .clk_i, .rst_ni, .ras_n_i, .cas_n_i, .oe_n_i,
    .rd_start_i(rd_start), .dq_oe_o
  );

  assign cycle_type_o = cyc;
endmodule

// File: rtl/dram_strobe_decoder_chk.sv
module dram_strobe_decoder_chk #(
  parameter int ADDR_W = 12,
  parameter int LANES  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ras_n_i,
  input logic [LANES-1:0]  cas_n_i,
  input logic [2:0]        cycle_type_o,
  input logic              test_mode_o,
  input logic [ADDR_W-1:0] row_o,
  input logic [ADDR_W-1:0] ref_row_o,
  input logic              wr_stb_o,
  input logic              dq_oe_o
);
  assert_wr_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o);

  assert_ewrite_hiz_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_type_o == 3'd6) |-> !dq_oe_o);

  assert_test_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_type_o == 3'd4) |-> test_mode_o);

  assert_refresh_row_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_type_o == 3'd2 || cycle_type_o == 3'd3) |-> (row_o == ref_row_o));

  assert_hiz_late_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_n_i && (&cas_n_i)) |=> !dq_oe_o);

  assert_ref_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(cycle_type_o) == 3'd2 || $past(cycle_type_o) == 3'd3) && cycle_type_o == 3'd0)
    |-> (ref_row_o == ADDR_W'($past(ref_row_o) + 1'b1)));
endmodule

bind dram_strobe_decoder dram_strobe_decoder_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk_i, .rst_ni, .ras_n_i, .cas_n_i, .cycle_type_o, .test_mode_o,
  .row_o, .ref_row_o, .wr_stb_o, .dq_oe_o
);

// File: tb/sim_dram_strobe_decoder.sv
module sim_dram_strobe_decoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic ras_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [3:0] cas_n = 4'hF;
  logic [11:0] addr = '0;
  logic [2:0] cyc;
  logic test_mode, wr_stb, dq_oe;
  logic [11:0] row, col, ref_row;
  logic [3:0] wr_lane;

  int tests = 0, fails = 0;
  int exp_ref = 0;
  bit done = 0;

  typedef struct { int sel; int exp; string tag; } item_t;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_strobe_decoder u0 (
    .clk_i(clk), .rst_ni, .ras_n_i(ras_n), .cas_n_i(cas_n), .we_n_i(we_n),
    .oe_n_i(oe_n), .addr_i(addr), .cycle_type_o(cyc), .test_mode_o(test_mode),
    .row_o(row), .col_o(col), .ref_row_o(ref_row), .wr_stb_o(wr_stb),
    .wr_lane_o(wr_lane), .dq_oe_o(dq_oe)
  );

  function automatic int peek(int sel);
    case (sel)
      0: return int'(cyc);
      1: return int'(row);
      2: return int'(col);
      3: return int'(ref_row);
      4: return int'(test_mode);
      5: return int'(dq_oe);
      6: return int'(wr_stb);
      default: return int'(wr_lane);
    endcase
  endfunction

  // monitor: compares queued expectations after each edge settles
  initial forever begin
    @(posedge clk); #2;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      tests++;
      if (peek(it.sel) != it.exp) begin
        fails++;
        $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.tag, it.sel, peek(it.sel), it.exp);
      end
    end
  end

  task automatic tick(input logic r, input logic [3:0] c, input logic w,
                      input logic o, input logic [11:0] a);
    @(negedge clk);
    ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a;
    @(posedge clk); #1;
  endtask

  task automatic expect_v(input int sel, input int v, input string tag);
    item_t it;
    it.sel = sel; it.exp = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic cbr(input bit chk);
    tick(1, 4'hE, 1, 1, 0);
    tick(0, 4'hE, 1, 1, 0);
    if (chk) begin
      expect_v(0, 2, "R2 cbr type");
      expect_v(1, exp_ref, "R2 cbr row");
    end
    tick(1, 4'hE, 1, 1, 0);
    exp_ref = (exp_ref + 1) % 4096;
    tick(1, 4'hF, 1, 1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    expect_v(0, 0, "R1 type"); expect_v(4, 0, "R1 test");
    expect_v(3, 0, "R1 ref"); expect_v(5, 0, "R1 oe"); expect_v(6, 0, "R1 wstb");
    @(negedge clk); rst_ni = 1'b1;

    // R4 row-only refresh
    tick(0, 4'hF, 1, 0, 12'h123);
    expect_v(0, 1, "R4 type"); expect_v(1, 'h123, "R4 row");
    tick(0, 4'hF, 1, 0, 12'h000);
    expect_v(5, 0, "R4 no output");
    tick(1, 4'hF, 1, 0, 0);
    expect_v(0, 0, "R4 end"); expect_v(3, 0, "R10 no step on row-only");

    // R2 counter refresh
    cbr(1);
    expect_v(3, exp_ref, "R10 step after cbr");

    // R7 read, RAS rises last -> R9
    tick(0, 4'hF, 1, 1, 12'h055);
    tick(0, 4'h0, 1, 0, 12'h0AA);
    expect_v(0, 5, "R7 type"); expect_v(2, 'h0AA, "R7 col"); expect_v(5, 1, "R7 oe");
    tick(0, 4'h0, 1, 1, 12'h0AA);
    expect_v(5, 0, "R7 oe pin high");
    tick(0, 4'hF, 1, 0, 0);
    expect_v(5, 1, "R9 cas rise first holds");
    tick(1, 4'hF, 1, 0, 0);
    expect_v(5, 0, "R9 ras rise last");

    // read, CAS rises last
    tick(0, 4'hF, 1, 0, 12'h011);
    tick(0, 4'h7, 1, 0, 12'h022);
    tick(1, 4'h7, 1, 0, 0);
    expect_v(5, 1, "R9 ras rise first holds");
    tick(1, 4'hF, 1, 0, 0);
    expect_v(5, 0, "R9 cas rise last");

    // R6 early write
    tick(0, 4'hF, 0, 0, 12'h044);
    tick(0, 4'hC, 0, 0, 12'h033);
    expect_v(0, 6, "R6 type"); expect_v(6, 1, "R6 strobe");
    expect_v(7, 3, "R6 lanes"); expect_v(5, 0, "R6 hiz");
    tick(0, 4'hC, 0, 0, 0);
    expect_v(6, 0, "R6 one pulse"); expect_v(5, 0, "R6 hiz hold");
    tick(1, 4'hF, 1, 1, 0);

    // R8 read-modify-write
    tick(0, 4'hF, 1, 0, 12'h066);
    tick(0, 4'h9, 1, 0, 12'h077);
    expect_v(0, 5, "R8 read first"); expect_v(5, 1, "R8 data shown");
    tick(0, 4'h9, 0, 0, 0);
    expect_v(0, 7, "R8 type"); expect_v(6, 1, "R8 strobe");
    expect_v(7, 6, "R8 lanes"); expect_v(5, 1, "R8 oe kept");
    tick(1, 4'hF, 1, 1, 0);

    // R5 hidden refresh after read
    tick(0, 4'hF, 1, 0, 12'h0F0);
    tick(0, 4'hE, 1, 0, 12'h00F);
    tick(1, 4'hE, 1, 0, 0);
    expect_v(0, 0, "R5 gap"); expect_v(5, 1, "R5 data held");
    tick(0, 4'hE, 1, 0, 0);
    expect_v(0, 3, "R5 type"); expect_v(1, exp_ref, "R5 row");
    expect_v(5, 1, "R5 data during refresh");
    tick(1, 4'hE, 1, 0, 0);
    exp_ref = (exp_ref + 1) % 4096;
    expect_v(3, exp_ref, "R10 step after hidden"); expect_v(5, 1, "R9 cas still low");
    tick(1, 4'hF, 1, 0, 0);
    expect_v(5, 0, "R9 hidden end");

    // R3 test entry, R11 exits
    tick(1, 4'hE, 0, 1, 0);
    tick(0, 4'hE, 0, 1, 0);
    expect_v(0, 4, "R3 type"); expect_v(4, 1, "R3 flag");
    tick(1, 4'hF, 1, 1, 0);
    tick(0, 4'hF, 1, 0, 12'h100);
    tick(0, 4'h0, 1, 0, 12'h001);
    tick(1, 4'hF, 1, 1, 0);
    expect_v(4, 1, "R11 access keeps test");
    tick(0, 4'hF, 1, 1, 12'h200);
    tick(1, 4'hF, 1, 1, 0);
    expect_v(4, 0, "R11 row-only exits");
    tick(1, 4'hE, 0, 1, 0);
    tick(0, 4'hE, 0, 1, 0);
    expect_v(4, 1, "R3 re-entry");
    tick(1, 4'hF, 1, 1, 0);
    tick(1, 4'hE, 1, 1, 0);
    tick(0, 4'hE, 1, 1, 0);
    expect_v(4, 0, "R11 cbr exits");
    tick(1, 4'hE, 1, 1, 0);
    exp_ref = (exp_ref + 1) % 4096;
    tick(1, 4'hF, 1, 1, 0);

    // R10 wrap
    while (exp_ref != 4095) cbr(0);
    expect_v(3, 4095, "R10 at top");
    cbr(1);
    expect_v(3, 0, "R10 wrap");

    repeat (2) @(posedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule